// File: doc/BRIEF.md
# Power-on reset sequencer

This block generates a design-wide, active-high reset without a dedicated reset pin. A down-counter wakes up from configuration already loaded with all ones through its declaration initializer. It then steps toward zero once per clock. The registered reset output stays high for as long as the count has not yet reached zero. The result is a reset of fixed, known length right after the device starts.

The block can optionally take an active-low external reset request. That request passes through a multi-stage synchronizer. While the request is present it reloads the counter to all ones and forces the output high. When the request is removed, the full internal interval runs again, so every external reset is stretched to the guaranteed length. A parameter removes the external path completely.

Top module: `por_reset_gen`

## Requirements
- R1: `rst` is high from time zero, before the first rising clock edge, with no external reset applied.
- R2: After power-up, with `ext_rst_n` held high, `rst` stays high for exactly 2^CNT_W − 1 clock cycles. It falls on the rising edge numbered 2^CNT_W − 1.
- R3: Once `rst` has fallen, it stays low for as long as no external request is seen.
- R4: With USE_EXT = 1, `ext_rst_n` going low between two edges makes `rst` high after the third rising edge that follows. The first two edges fill the two-stage synchronizer.
- R5: `rst` stays high for the whole time that the synchronized external request is present.
- R6: When `ext_rst_n` returns high between two edges, `rst` falls on the (2^CNT_W + 1)-th rising edge after that point. This is a full interval of 2^CNT_W − 1 cycles after the last edge at which the request was seen.
- R7: An external request that arrives during the power-up interval reloads the counter. The interval is counted again from its release, as in R6.
- R8: With USE_EXT = 0, `ext_rst_n` has no effect: `rst` ends after the power-up interval of R2 and stays low whatever the input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| ext_rst_n | input | 1 | Optional asynchronous external reset request, active low |
| rst | output | 1 | Registered design-wide reset, active high |

## Verification
The cycle at which reset ends is the main target. A counter that tested the current count instead of the next one, or a reset that was not registered, would give a reset one cycle too long or too short. The bench sweeps external pulse widths from one to five cycles and checks the rise edge and the fall edge of each. A missing synchronizer stage shifts the rise, and a release that fails to reload the counter shortens the tail. A pulse placed inside the power-up window catches a design that lets the first count finish. A second configuration without the external path shows whether the request leaks through.

// File: rtl/por_pkg.sv
package por_pkg;

   // Number of reset cycles produced by a counter of the given width.
   function automatic longint unsigned por_len(input int unsigned w);
      return (longint'(1) << w) - 1;
   endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d_n,
   output logic q_n
);
   // Each stage powers up in the deasserted (high) state.
   logic [STAGES-1:0] stg = '1;

   always_ff @(posedge clk) stg[0] <= d_n;

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stg[i] <= stg[i-1];
   end

   assign q_n = stg[STAGES-1];
endmodule

// File: rtl/por_down_counter.sv
module por_down_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             reload,
   output logic [CNT_W-1:0] cnt,
   output logic             busy_next
);
   localparam logic [CNT_W-1:0] FULL = '1;
   localparam logic [CNT_W-1:0] ZERO = '0;

   // Power-up value comes from the initializer, not from a reset.
   logic [CNT_W-1:0] cnt_q = FULL;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (reload)
         cnt_d = FULL;
      else if (cnt_q != ZERO)
         cnt_d = cnt_q - 1'b1;
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk) cnt_q <= cnt_d;

   assign cnt       = cnt_q;
   assign busy_next = (cnt_d != ZERO);
endmodule

// File: rtl/por_reset_gen.sv
module por_reset_gen #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          USE_EXT     = 1'b1
) (
   input  logic clk,
   input  logic ext_rst_n,
   output logic rst
);
   import por_pkg::*;

   localparam longint unsigned RST_CYCLES = por_len(CNT_W);

   initial begin
      if (CNT_W < 2 || CNT_W > 32)
         $error("por_reset_gen: CNT_W must lie in 2..32");
      if (SYNC_STAGES < 2)
         $error("por_reset_gen: SYNC_STAGES must be at least 2");
      if (RST_CYCLES < 3)
         $error("por_reset_gen: reset interval too short");
   end

   logic             ext_sync_n;
   logic             ext_seen;
   logic [CNT_W-1:0] cnt;
   logic             busy_next;

   // External request path: present only when USE_EXT is set.
   generate
      if (USE_EXT) begin : g_ext
         por_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .d_n (ext_rst_n),
            .q_n (ext_sync_n)
         );
         assign ext_seen = ~ext_sync_n;
      end else begin : g_no_ext
         assign ext_sync_n = ext_rst_n;
         assign ext_seen   = 1'b0 & ~ext_sync_n;
      end
   endgenerate

   por_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .reload    (ext_seen),
      .cnt       (cnt),
      .busy_next (busy_next)
   );

   // Registered output, high from configuration onward.
   logic rst_q = 1'b1;

   always_ff @(posedge clk) rst_q <= busy_next;

   assign rst = rst_q;
endmodule

// File: rtl/por_reset_gen_chk.sv
module por_reset_gen_chk #(
   parameter int unsigned CNT_W   = 8,
   parameter bit          USE_EXT = 1'b1
) (
   input logic             clk,
   input logic             ext_rst_n,
   input logic             ext_seen,
   input logic [CNT_W-1:0] cnt,
   input logic             rst
);
   localparam logic [CNT_W-1:0] FULL = '1;

   // Edges seen since time zero, saturating; stands in for a reset.
   logic [1:0] age = 2'd0;
   always_ff @(posedge clk) if (age != 2'd3) age <= age + 2'd1;

   // R1 R3: the output tracks whether the count is still running.
   a_r1_rst_tracks_count: assert property (@(posedge clk)
      rst == (cnt != '0));

   // R2: the count steps down by one when no request is present.
   a_r2_count_down: assert property (@(posedge clk) disable iff (age == 2'd0)
      (cnt != '0 && !ext_seen) |=> cnt == $past(cnt) - 1'b1);

   // R3: an exhausted count stays at zero without a request.
   a_r3_hold_zero: assert property (@(posedge clk) disable iff (age == 2'd0)
      (cnt == '0 && !ext_seen) |=> (cnt == '0 && !rst));

   // R5: a seen request reloads the count and holds reset.
   a_r5_reload: assert property (@(posedge clk) disable iff (age == 2'd0)
      ext_seen |=> (cnt == FULL && rst));

   // R4: a request only appears after the pin was low two edges earlier.
   a_r4_sync_delay: assert property (@(posedge clk) disable iff (age < 2'd2)
      $rose(ext_seen) |-> !$past(ext_rst_n, 2));

   generate
      if (!USE_EXT) begin : g_noext_chk
         // R8: without the external path the request never appears.
         a_r8_no_ext: assert property (@(posedge clk) !ext_seen);
      end
   endgenerate
endmodule

bind por_reset_gen por_reset_gen_chk #(.CNT_W(CNT_W), .USE_EXT(USE_EXT)) u_chk (
   .clk       (clk),
   .ext_rst_n (ext_rst_n),
   .ext_seen  (ext_seen),
   .cnt       (cnt),
   .rst       (rst)
);

// File: tb/tb_por_reset_gen.sv
module tb_por_reset_gen;
   localparam int W_A   = 4;
   localparam int W_B   = 3;
   localparam int LEN_A = (1 << W_A) - 1;   // 15
   localparam int LEN_B = (1 << W_B) - 1;   // 7

   logic clk = 1'b0;
   logic ext_n = 1'b1;     // shared by dut and dut_b
   logic ext_c = 1'b1;     // dut_c only
   logic rst_a, rst_b, rst_c;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   por_reset_gen #(.CNT_W(W_A), .SYNC_STAGES(2), .USE_EXT(1'b1)) dut (
      .clk(clk), .ext_rst_n(ext_n), .rst(rst_a));
   por_reset_gen #(.CNT_W(W_B), .SYNC_STAGES(2), .USE_EXT(1'b0)) dut_b (
      .clk(clk), .ext_rst_n(ext_n), .rst(rst_b));
   por_reset_gen #(.CNT_W(W_A), .SYNC_STAGES(2), .USE_EXT(1'b1)) dut_c (
      .clk(clk), .ext_rst_n(ext_c), .rst(rst_c));

   task automatic chk(input string tag, input string who, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at %0t: rst=%b expected %b", tag, who, $time, act, exp);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset present before any clock edge.
      #1;
      chk("R1", "dut", rst_a, 1'b1);
      chk("R1", "dut_b", rst_b, 1'b1);
      chk("R1", "dut_c", rst_c, 1'b1);

      // Power-up window; k counts rising edges seen so far.
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         chk(k < LEN_A ? "R2" : "R3", "dut", rst_a, logic'(k < LEN_A));
         chk(k < LEN_B ? "R2" : "R3", "dut_b", rst_b, logic'(k < LEN_B));
         // R7: request during power-up, driven after edge 5, released after edge 7.
         chk("R7", "dut_c", rst_c, logic'(k < 7 + 1 + (LEN_A + 1)));
         if (k == 5) ext_c = 1'b0;
         if (k == 7) ext_c = 1'b1;
      end

      // R4 R5 R6 R8: sweep external pulse widths.
      for (int w = 1; w <= 5; w++) begin
         ext_n = 1'b0;
         for (int t = 1; t <= w + LEN_A + 6; t++) begin
            @(negedge clk);
            if (t < 3)
               chk("R4", "dut", rst_a, 1'b0);
            else if (t == 3)
               chk("R4", "dut", rst_a, 1'b1);
            else if (t <= w + LEN_A + 1)
               chk(t <= w + 2 ? "R5" : "R6", "dut", rst_a, 1'b1);
            else
               chk("R6", "dut", rst_a, 1'b0);
            chk("R8", "dut_b", rst_b, 1'b0);
            if (t == w) ext_n = 1'b1;
         end
      end

      // R3: long idle stretch with no request.
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         chk("R3", "dut", rst_a, 1'b0);
         chk("R3", "dut_c", rst_c, 1'b0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule